// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

This block is a serial shift register with a parameterised number of stages, 32 by default, numbered 1 to STAGES. One control input sets the direction of travel. A second control input chooses the bit that enters the register. That bit is either the serial input assigned to the current direction, or the bit leaving the far end, which turns the shift into a rotate. A freeze input stops every stage for as long as it is high.

Each direction has its own serial input. There are two serial outputs, one at each end of the chain, and both come straight from stage flops. The whole stage vector is also brought out so that the full contents can be read. Everything runs on the rising edge of one clock. An active-low asynchronous reset clears the contents.

Top module: `bidir_rotate_shifter`

## Requirements
- R1: While `rst_n` is low, every stage and both serial outputs read 0. This takes effect at once, without a clock edge.
- R2: On a rising edge with `freeze`=0 and `shift_left`=0 (shift right), stage k+1 takes the old value of stage k for k from 1 to STAGES-1.
- R3: In a right shift with `load_ext`=1, stage 1 takes `sin_right`.
- R4: In a right shift with `load_ext`=0, stage 1 takes the old value of stage STAGES.
- R5: On a rising edge with `freeze`=0 and `shift_left`=1 (shift left), stage k takes the old value of stage k+1 for k from 1 to STAGES-1.
- R6: In a left shift with `load_ext`=1, stage STAGES takes `sin_left`.
- R7: In a left shift with `load_ext`=0, stage STAGES takes the old value of stage 1.
- R8: When `freeze`=1 at a rising edge, every stage and both outputs keep their values. `shift_left`, `load_ext`, `sin_left` and `sin_right` have no effect.
- R9: `sout_left` always equals stage 1 and `sout_right` always equals stage STAGES. Both change on the same edge as the stages.
- R10: With `load_ext`=0 and `freeze`=0, STAGES consecutive shifts in one direction bring the contents back to their starting value.
- R11: A change of `shift_left` between edges applies from the next rising edge. Each edge moves the contents by exactly one stage, with no bit lost or duplicated.
- R12: `taps` bit i-1 shows stage i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge is active |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_left | input | 1 | 1 = shift toward stage 1, 0 = shift toward stage STAGES |
| load_ext | input | 1 | 1 = entry bit from the serial input for the current direction, 0 = rotate |
| freeze | input | 1 | 1 = hold all stages |
| sin_right | input | 1 | Serial input that enters stage 1 in a right shift |
| sin_left | input | 1 | Serial input that enters stage STAGES in a left shift |
| sout_left | output | 1 | Value of stage 1 |
| sout_right | output | 1 | Value of stage STAGES |
| taps | output | STAGES | Whole stage vector; bit i-1 is stage i |

## Verification
The main interaction in a single cycle is between the freeze hold and a direction change, and between the freeze hold and the choice of entry source. The table of vectors places freeze cycles between rows that reverse direction and switch between external input and rotate. The serial inputs toggle during those freeze cycles. After every edge the stage vector and both outputs are compared with a reference model built from the requirements. Each row must show either a single one-stage move or no change at all.

// File: rtl/shr_pkg.sv
package shr_pkg;

   typedef enum logic {
      DIR_RIGHT = 1'b0,
      DIR_LEFT  = 1'b1
   } shr_dir_e;

   localparam int unsigned SHR_MIN_STAGES = 2;

endpackage

// File: rtl/shr_entry_sel.sv
module shr_entry_sel (
   input  logic load_ext,
   input  logic sin_right,
   input  logic sin_left,
   input  logic first_q,
   input  logic last_q,
   output logic right_entry,
   output logic left_entry
);

   // In a right shift stage 1 takes the new bit: the external input, or stage N wrapping round.
   always_comb begin
      if (load_ext) right_entry = sin_right;
      else          right_entry = last_q;
   end

   // In a left shift stage N takes the new bit: the external input, or stage 1 wrapping round.
   always_comb begin
      if (load_ext) left_entry = sin_left;
      else          left_entry = first_q;
   end

endmodule

// File: rtl/shr_stage.sv
module shr_stage
   import shr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hold,
   input  shr_dir_e dir,
   input  logic     from_lower,
   input  logic     from_upper,
   output logic     q
);

   logic d;

   always_comb begin
      if (hold)                d = q;
      else if (dir == DIR_LEFT) d = from_upper;
      else                     d = from_lower;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end

endmodule

// File: rtl/bidir_rotate_shifter.sv
module bidir_rotate_shifter
   import shr_pkg::*;
#(
   parameter int unsigned STAGES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_left,
   input  logic              load_ext,
   input  logic              freeze,
   input  logic              sin_right,
   input  logic              sin_left,
   output logic              sout_left,
   output logic              sout_right,
   output logic [STAGES-1:0] taps
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < SHR_MIN_STAGES) begin : g_bad_stages
         $error("bidir_rotate_shifter: STAGES must be at least 2");
      end
   endgenerate

   shr_dir_e    dir;
   logic        right_entry;
   logic        left_entry;
   logic [LAST:0] q;

   assign dir = shr_dir_e'(shift_left);

   shr_entry_sel u_entry (
      .load_ext    (load_ext),
      .sin_right   (sin_right),
      .sin_left    (sin_left),
      .first_q     (q[0]),
      .last_q      (q[LAST]),
      .right_entry (right_entry),
      .left_entry  (left_entry)
   );

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         logic lower_src;
         logic upper_src;
         if (i == 0) begin : g_first
            assign lower_src = right_entry;
            assign upper_src = q[1];
         end else if (i == LAST) begin : g_last
            assign lower_src = q[LAST-1];
            assign upper_src = left_entry;
         end else begin : g_mid
            assign lower_src = q[i-1];
            assign upper_src = q[i+1];
         end

         shr_stage u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold       (freeze),
            .dir        (dir),
            .from_lower (lower_src),
            .from_upper (upper_src),
            .q          (q[i])
         );
      end
   endgenerate

   assign taps       = q;
   assign sout_left  = q[0];
   assign sout_right = q[LAST];

endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
   parameter int unsigned STAGES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shift_left,
   input logic              load_ext,
   input logic              freeze,
   input logic              sin_right,
   input logic              sin_left,
   input logic              sout_left,
   input logic              sout_right,
   input logic [STAGES-1:0] taps
);

   localparam int unsigned LAST = STAGES - 1;

   AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(taps)); // R8

   AST_RIGHT_BODY: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !shift_left) |=> taps[LAST:1] == $past(taps[LAST-1:0])); // R2

   AST_RIGHT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !shift_left && load_ext) |=> taps[0] == $past(sin_right)); // R3

   AST_RIGHT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !shift_left && !load_ext) |=> taps[0] == $past(taps[LAST])); // R4

   AST_LEFT_BODY: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && shift_left) |=> taps[LAST-1:0] == $past(taps[LAST:1])); // R5

   AST_LEFT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && shift_left && load_ext) |=> taps[LAST] == $past(sin_left)); // R6

   AST_LEFT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && shift_left && !load_ext) |=> taps[LAST] == $past(taps[0])); // R7

   AST_SOUT_RIGHT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !shift_left) |=> sout_right == $past(taps[LAST-1])); // R9

   AST_SOUT_LEFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && shift_left) |=> sout_left == $past(taps[1])); // R9

   AST_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> ($stable(sout_left) && $stable(sout_right))); // R8

endmodule

bind bidir_rotate_shifter shr_checker #(.STAGES(STAGES)) u_shr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .shift_left (shift_left),
   .load_ext   (load_ext),
   .freeze     (freeze),
   .sin_right  (sin_right),
   .sin_left   (sin_left),
   .sout_left  (sout_left),
   .sout_right (sout_right),
   .taps       (taps)
);

// File: tb/tb_bidir_rotate_shifter.sv
module tb_bidir_rotate_shifter;

   localparam int unsigned STAGES = 32;
   localparam time         CLK_PERIOD = 10;
   localparam int          NVEC = 18;

   // row fields: {shift_left, load_ext, freeze, sin_left, sin_right}
   localparam logic [4:0] VEC [0:NVEC-1] = '{
      5'b01001, 5'b01001, 5'b01000, 5'b01001, 5'b00000,
      5'b00101, 5'b00110, 5'b11010, 5'b11000, 5'b10000,
      5'b10111, 5'b01101, 5'b00000, 5'b10000, 5'b11100,
      5'b01001, 5'b10000, 5'b00000
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_left = 1'b0;
   logic load_ext = 1'b0;
   logic freeze = 1'b0;
   logic sin_right = 1'b0;
   logic sin_left = 1'b0;
   logic sout_left;
   logic sout_right;
   logic [STAGES-1:0] taps;

   logic [STAGES-1:0] model = '0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bidir_rotate_shifter #(.STAGES(STAGES)) dut (
      .clk (clk), .rst_n (rst_n), .shift_left (shift_left), .load_ext (load_ext),
      .freeze (freeze), .sin_right (sin_right), .sin_left (sin_left),
      .sout_left (sout_left), .sout_right (sout_right), .taps (taps)
   );

   task automatic check_all(input string tag);
      n_checks++;
      if (taps !== model) begin
         n_fail++;
         $display("FAIL %s taps actual=%h expected=%h", tag, taps, model);
      end
      n_checks++;
      if (sout_left !== model[0] || sout_right !== model[STAGES-1]) begin
         n_fail++;
         $display("FAIL R9 (%s) outputs actual=%b%b expected=%b%b", tag,
                  sout_left, sout_right, model[0], model[STAGES-1]);
      end
   endtask

   // Reference model from R2..R8.
   task automatic step(input logic d, input logic e, input logic h,
                       input logic sl, input logic sr, input string tag);
      logic nb;
      shift_left = d; load_ext = e; freeze = h; sin_left = sl; sin_right = sr;
      @(posedge clk);
      if (!h) begin
         if (!d) begin
            nb = e ? sr : model[STAGES-1];
            model = {model[STAGES-2:0], nb};
         end else begin
            nb = e ? sl : model[0];
            model = {nb, model[STAGES-1:1]};
         end
      end
      @(negedge clk);
      check_all(tag);
   endtask

   function automatic string tag_of(input logic d, input logic e, input logic h);
      if (h)           return "R8";
      if (!d && e)     return "R2 R3";
      if (!d && !e)    return "R2 R4";
      if (d && e)      return "R5 R6";
      return "R5 R7";
   endfunction

   initial begin
      logic [STAGES-1:0] snap;
      logic prev_dir;
      string tg;
      // R1: reset state with no clock edge needed
      #1;
      check_all("R1 reset");
      @(negedge clk); @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk; rows with a reversed direction are tagged R11.
      prev_dir = 1'b0;
      for (int k = 0; k < NVEC; k++) begin
         tg = tag_of(VEC[k][4], VEC[k][3], VEC[k][2]);
         if (!VEC[k][2] && VEC[k][4] != prev_dir) tg = {"R11 ", tg};
         if (!VEC[k][2]) prev_dir = VEC[k][4];
         step(VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0], tg);
      end

      // Load a known pattern through the right input (R3, R12).
      for (int k = 0; k < STAGES; k++) begin
         logic [31:0] pat;
         pat = 32'hA5C3_1E97;
         step(1'b0, 1'b1, 1'b0, 1'b0, pat[k], "R3 R12");
      end
      snap = model;

      // R10: full rotate right returns the contents
      for (int k = 0; k < STAGES; k++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
      n_checks++;
      if (taps !== snap) begin
         n_fail++;
         $display("FAIL R10 right rotate actual=%h expected=%h", taps, snap);
      end
      // R10: full rotate left returns the contents
      for (int k = 0; k < STAGES; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      n_checks++;
      if (taps !== snap) begin
         n_fail++;
         $display("FAIL R10 left rotate actual=%h expected=%h", taps, snap);
      end

      // R8: freeze with every other input toggling
      for (int k = 0; k < 8; k++)
         step(k[0], k[1], 1'b1, ~k[0], k[2], "R8");
      n_checks++;
      if (taps !== snap) begin
         n_fail++;
         $display("FAIL R8 freeze actual=%h expected=%h", taps, snap);
      end

      // R11: alternate direction each edge with wrap; net movement is zero
      for (int k = 0; k < 6; k++) step(k[0], 1'b0, 1'b0, 1'b1, 1'b1, "R11");
      n_checks++;
      if (taps !== snap) begin
         n_fail++;
         $display("FAIL R11 alternate actual=%h expected=%h", taps, snap);
      end

      // R1: asynchronous reset away from any edge
      #(CLK_PERIOD/4);
      rst_n = 1'b0;
      model = '0;
      #1;
      check_all("R1 async");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5 R6");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule